// File: doc/BRIEF.md
# Filtered Input Capture Channel

This block is one capture channel of a timer. It takes an asynchronous input, or the XOR of three input lines, passes it through a two-flop synchroniser and a digital glitch filter of programmable length, and picks out rising edges, falling edges or both. An event prescaler keeps only every 1st, 2nd, 4th or 8th qualifying edge. On each kept edge the channel copies the value of a shared free-running counter into its capture register and raises a capture flag. If the previous capture was never read, it also raises an overcapture flag.

The counter is outside the block and arrives on the `count` port. When clear-on-capture is enabled, the channel sends a one-cycle reset request to that counter just after each capture. The next capture then holds the time since the previous kept edge, which is the input period. The three-line XOR mode suits sensors whose edges are spread across three wires: an edge on any of the three lines produces a capture.

Top module: `icap_channel`

## Requirements
- R1: `edgeSel` selects the qualifying edges of the filtered signal: 2'b00 rising only, 2'b01 falling only, 2'b10 or 2'b11 both. A pulse that qualifies only for the other polarity never causes a capture.
- R2: `preSel` sets the prescale: 2'b00 keeps every qualifying edge, 2'b01 every 2nd, 2'b10 every 4th and 2'b11 every 8th. The edges are counted from reset, and the first edge kept is the Nth one.
- R3: The filtered level takes a new value only after `filtLen` consecutive synchronised samples at that value. A value of 0 acts as 1. A sample that agrees with the current filtered level restarts the run, so a glitch shorter than `filtLen` samples produces no edge.
- R4: After a clean input change that lands before clock edge 1, `capFlag` is visible after clock edge `filtLen`+3: two synchroniser stages, `filtLen` filter samples and one capture stage.
- R5: On a capture, `capValue` takes the value `count` had in the cycle the kept edge was recognised. Without a capture, `capValue` holds its value.
- R6: `capFlag` is set by a capture and cleared by a `capRead` pulse. When both occur in the same cycle, the capture wins.
- R7: `ovcFlag` is set when a capture occurs while `capFlag` is already 1 and `capRead` is low. Only `ovcClr` clears it; `capRead` leaves it unchanged. A set in the same cycle as a clear wins.
- R8: With `clrOnCap`=1, `ctrReset` pulses high for one cycle, in the cycle after each capture. With `clrOnCap`=0 it stays low.
- R9: With `xorMode`=1, the filter input is the XOR of the three synchronised lines `sigIn[0]`, `sigIn[1]` and `sigIn[2]`. With `xorMode`=0 only `sigIn[0]` is used, and `sigIn[1]` and `sigIn[2]` have no effect.
- R10: While `rstN` is low, `capValue`, `capFlag`, `ovcFlag` and `ctrReset` are 0, and the filtered level and the prescale count return to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sigIn | input | 3 | Asynchronous input lines; line 0 is the only one used unless XOR mode is on |
| xorMode | input | 1 | Filter input is the XOR of the three lines |
| edgeSel | input | 2 | Edge polarity select |
| preSel | input | 2 | Event prescale select |
| filtLen | input | FW (4) | Number of consecutive agreeing samples the filter needs |
| clrOnCap | input | 1 | Request a counter reset after each capture |
| count | input | CW (16) | Shared free-running counter value |
| capRead | input | 1 | Read strobe for the capture register; clears the capture flag |
| ovcClr | input | 1 | Clears the overcapture flag |
| capValue | output | CW (16) | Capture register |
| capFlag | output | 1 | Capture pending |
| ovcFlag | output | 1 | Overcapture occurred |
| ctrReset | output | 1 | One-cycle reset request to the shared counter |

## Verification
The bench drives square pulses on line 0 in each edge mode. Comparing the capture counts for rising, falling and both edges separates the polarity decode from the prescaler. Runs with every 2nd, 4th and 8th edge kept check the division, and the latency of a single clean edge pins the pipeline depth. Glitches one sample shorter than the filter length, followed by a pulse just long enough to pass, show that the filter run restarts. Toggling lines 1 and 2 with XOR mode on and then off shows that the extra lines only matter in that mode. Back-to-back unread captures, with reads and clears in between, show the separate clearing of the two flags. A behavioural model compares `capValue`, both flags and `ctrReset` on every clock.

// File: rtl/icap_pkg.sv
package icap_pkg;

  typedef enum logic [1:0] {
    SEL_RISE     = 2'd0,
    SEL_FALL     = 2'd1,
    SEL_BOTH     = 2'd2,
    SEL_BOTH_ALT = 2'd3
  } edgeSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic capLoad;  // load capture register this cycle
    logic rstReq;   // request counter reset next cycle
  } capStrobe_t;

endpackage

// File: rtl/icap_front.sv
module icap_front #(
  parameter int NLINES = 3,
  parameter int FW     = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NLINES-1:0] sigIn,
  input  logic              xorMode,
  input  logic [FW-1:0]     filtLen,
  output logic              riseP,
  output logic              fallP
);

  logic [NLINES-1:0] syncA;
  logic [NLINES-1:0] syncB;

  // two-flop synchroniser per line
  for (genvar g = 0; g < NLINES; g++) begin : g_sync
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        syncA[g] <= 1'b0;
        syncB[g] <= 1'b0;
      end else begin
        syncA[g] <= sigIn[g];
        syncB[g] <= syncA[g];
      end
    end
  end

  logic rawLvl;
  assign rawLvl = xorMode ? ^syncB : syncB[0];

  logic          filtLvl;
  logic [FW-1:0] runCnt;
  logic [FW:0]   effLen;
  logic [FW:0]   runNext;
  logic          accept;

  assign effLen  = (filtLen == '0) ? {{FW{1'b0}}, 1'b1} : {1'b0, filtLen};
  assign runNext = {1'b0, runCnt} + 1'b1;
  assign accept  = (rawLvl != filtLvl) && (runNext >= effLen);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      filtLvl <= 1'b0;
      runCnt  <= '0;
      riseP   <= 1'b0;
      fallP   <= 1'b0;
    end else begin
      riseP <= accept & rawLvl;
      fallP <= accept & ~rawLvl;
      if (rawLvl == filtLvl) begin
        runCnt <= '0;
      end else if (accept) begin
        filtLvl <= rawLvl;
        runCnt  <= '0;
      end else begin
        runCnt <= runNext[FW-1:0];
      end
    end
  end

  // R3: an agreeing sample never moves the filtered level
  p_front_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (rawLvl == filtLvl) |=> $stable(filtLvl));

  // R1: an edge pulse is never both rising and falling
  p_onehot_edge_r1: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({riseP, fallP}));

endmodule

// File: rtl/icap_ctrl.sv
module icap_ctrl
  import icap_pkg::*;
#(
  parameter int PSW = 2
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           riseP,
  input  logic           fallP,
  input  logic [1:0]     edgeSel,
  input  logic [PSW-1:0] preSel,
  input  logic           clrOnCap,
  input  logic           capRead,
  input  logic           ovcClr,
  output capStrobe_t     strb,
  output logic           capFlag,
  output logic           ovcFlag
);

  localparam int PCW = (1 << PSW) - 1;

  logic qualEdge;
  always_comb begin
    unique case (edgeSel_e'(edgeSel))
      SEL_RISE: qualEdge = riseP;
      SEL_FALL: qualEdge = fallP;
      default:  qualEdge = riseP | fallP;
    endcase
  end

  logic [PCW-1:0] preCnt;
  logic [PCW:0]   preLim;
  logic           capture;

  assign preLim  = ({{PCW{1'b0}}, 1'b1} << preSel) - 1'b1;
  assign capture = qualEdge && ({1'b0, preCnt} >= preLim);

  assign strb.capLoad = capture;
  assign strb.rstReq  = capture & clrOnCap;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt  <= '0;
      capFlag <= 1'b0;
      ovcFlag <= 1'b0;
    end else begin
      if (qualEdge) preCnt <= capture ? '0 : preCnt + 1'b1;
      if (capture)      capFlag <= 1'b1;
      else if (capRead) capFlag <= 1'b0;
      if (capture && capFlag && !capRead) ovcFlag <= 1'b1;
      else if (ovcClr)                    ovcFlag <= 1'b0;
    end
  end

  // R6: a capture always leaves the flag set
  p_flag_set_r6: assert property (@(posedge clk) disable iff (!rstN)
    strb.capLoad |=> capFlag);

  // R6: a read with no capture clears the flag
  p_read_clears_r6: assert property (@(posedge clk) disable iff (!rstN)
    (capRead && !strb.capLoad) |=> !capFlag);

  // R7: reads do not clear overcapture
  p_ovc_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    (ovcFlag && !ovcClr) |=> ovcFlag);

endmodule

// File: rtl/icap_dpath.sv
module icap_dpath
  import icap_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  capStrobe_t    strb,
  input  logic [CW-1:0] count,
  output logic [CW-1:0] capValue,
  output logic          ctrReset
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      capValue <= '0;
      ctrReset <= 1'b0;
    end else begin
      if (strb.capLoad) capValue <= count;
      ctrReset <= strb.rstReq;
    end
  end

  // R5: the register holds when no capture is strobed
  p_capval_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    !strb.capLoad |=> $stable(capValue));

  // R5: a load takes the counter of the strobe cycle
  p_capval_load_r5: assert property (@(posedge clk) disable iff (!rstN)
    strb.capLoad |=> (capValue == $past(count)));

endmodule

// File: rtl/icap_channel.sv
module icap_channel
  import icap_pkg::*;
#(
  parameter int CW = 16,
  parameter int FW = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [2:0]    sigIn,
  input  logic          xorMode,
  input  logic [1:0]    edgeSel,
  input  logic [1:0]    preSel,
  input  logic [FW-1:0] filtLen,
  input  logic          clrOnCap,
  input  logic [CW-1:0] count,
  input  logic          capRead,
  input  logic          ovcClr,
  output logic [CW-1:0] capValue,
  output logic          capFlag,
  output logic          ovcFlag,
  output logic          ctrReset
);

  logic       riseP;
  logic       fallP;
  capStrobe_t strb;

  icap_front #(.NLINES(3), .FW(FW)) front_i (
    .clk     (clk),
    .rstN    (rstN),
    .sigIn   (sigIn),
    .xorMode (xorMode),
    .filtLen (filtLen),
    .riseP   (riseP),
    .fallP   (fallP)
  );

  icap_ctrl #(.PSW(2)) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .riseP    (riseP),
    .fallP    (fallP),
    .edgeSel  (edgeSel),
    .preSel   (preSel),
    .clrOnCap (clrOnCap),
    .capRead  (capRead),
    .ovcClr   (ovcClr),
    .strb     (strb),
    .capFlag  (capFlag),
    .ovcFlag  (ovcFlag)
  );

  icap_dpath #(.CW(CW)) dpath_i (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .count    (count),
    .capValue (capValue),
    .ctrReset (ctrReset)
  );

endmodule

// File: tb/icap_channel_tb_top.sv
module icap_channel_tb_top;

  localparam int CW = 16;
  localparam int FW = 4;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [2:0]    sigIn = '0;
  logic          xorMode = 1'b0;
  logic [1:0]    edgeSel = 2'd0;
  logic [1:0]    preSel = 2'd0;
  logic [FW-1:0] filtLen = 4'd2;
  logic          clrOnCap = 1'b0;
  logic [CW-1:0] count;
  logic          capRead;
  logic          ovcClr = 1'b0;
  logic [CW-1:0] capValue;
  logic          capFlag;
  logic          ovcFlag;
  logic          ctrReset;

  logic autoRd = 1'b0;
  logic autoPulse = 1'b0;
  logic manRd = 1'b0;
  assign capRead = autoPulse | manRd;

  int nChecks = 0;
  int nFails = 0;
  int nCaps = 0;
  int nCtr = 0;
  int cycles = 0;
  logic prevFlag = 1'b0;
  logic done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  icap_channel #(.CW(CW), .FW(FW)) dut_i (
    .clk(clk), .rstN(rstN), .sigIn(sigIn), .xorMode(xorMode),
    .edgeSel(edgeSel), .preSel(preSel), .filtLen(filtLen),
    .clrOnCap(clrOnCap), .count(count), .capRead(capRead),
    .ovcClr(ovcClr), .capValue(capValue), .capFlag(capFlag),
    .ovcFlag(ovcFlag), .ctrReset(ctrReset)
  );

  // shared counter owned by the bench
  always @(posedge clk or negedge rstN) begin
    if (!rstN)         count <= '0;
    else if (ctrReset) count <= '0;
    else               count <= count + 1'b1;
  end

  // behavioural reference model
  logic [2:0]    mS1, mS2;
  logic          mLvl, mRise, mFall, mFlag, mOvc, mCtr;
  int            mRun, mPre;
  logic [CW-1:0] mVal;

  always @(posedge clk) begin
    if (!rstN) begin
      mS1 = 0; mS2 = 0; mLvl = 0; mRise = 0; mFall = 0;
      mFlag = 0; mOvc = 0; mCtr = 0; mRun = 0; mPre = 0; mVal = 0;
    end else begin
      logic raw, qual, cap, acc;
      int eff, lim;
      raw = xorMode ? (mS2[0] ^ mS2[1] ^ mS2[2]) : mS2[0];
      eff = (filtLen == 0) ? 1 : int'(filtLen);
      if (edgeSel == 2'd0)      qual = mRise;
      else if (edgeSel == 2'd1) qual = mFall;
      else                      qual = mRise | mFall;
      lim = (1 << preSel) - 1;
      cap = qual && (mPre >= lim);
      mCtr = cap && clrOnCap;
      if (cap) mVal = count;
      if (cap && mFlag && !capRead) mOvc = 1;
      else if (ovcClr)              mOvc = 0;
      if (cap)          mFlag = 1;
      else if (capRead) mFlag = 0;
      if (qual) mPre = cap ? 0 : mPre + 1;
      acc = (raw != mLvl) && (mRun + 1 >= eff);
      mRise = acc && raw;
      mFall = acc && !raw;
      if (raw == mLvl) mRun = 0;
      else if (acc) begin mLvl = raw; mRun = 0; end
      else mRun = mRun + 1;
      mS2 = mS1;
      mS1 = sigIn;
    end
  end

  task automatic check(string req, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // per-cycle compare, observation and auto read, all at the falling edge
  always @(negedge clk) begin
    cycles++;
    if (rstN && !done) begin
      check("R5 capValue vs model", int'(capValue), int'(mVal));
      check("R6 capFlag vs model", int'(capFlag), int'(mFlag));
      check("R7 ovcFlag vs model", int'(ovcFlag), int'(mOvc));
      check("R8 ctrReset vs model", int'(ctrReset), int'(mCtr));
      if (capFlag && !prevFlag) nCaps++;
      if (ctrReset) nCtr++;
    end
    prevFlag = capFlag;
    autoPulse = autoRd && capFlag;
  end

  always @(negedge clk) begin
    if (cycles > 150000 && !done) begin
      done = 1'b1;
      nFails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 150000);
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  task automatic do_reset();
    rstN = 1'b0;
    sigIn = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    nCaps = 0;
    nCtr = 0;
    repeat (2) @(negedge clk);
  endtask

  task automatic pulse(int line, int hi, int lo);
    sigIn[line] = 1'b1;
    repeat (hi) @(negedge clk);
    sigIn[line] = 1'b0;
    repeat (lo) @(negedge clk);
  endtask

  task automatic pulses(int n);
    for (int i = 0; i < n; i++) pulse(0, 6, 6);
    repeat (12) @(negedge clk);
  endtask

  initial begin
    int k;
    autoRd = 1'b1;

    // R10 reset state
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    check("R10 capValue in reset", int'(capValue), 0);
    check("R10 flags in reset", int'({capFlag, ovcFlag, ctrReset}), 0);
    do_reset();

    // R1 polarity
    edgeSel = 2'd0; do_reset(); pulses(3);
    check("R1 rising captures", nCaps, 3);
    edgeSel = 2'd1; do_reset(); pulses(3);
    check("R1 falling captures", nCaps, 3);
    edgeSel = 2'd2; do_reset(); pulses(3);
    check("R1 both-edge captures", nCaps, 6);

    // R2 prescaler
    edgeSel = 2'd0; preSel = 2'd1; do_reset(); pulses(4);
    check("R2 every 2nd edge", nCaps, 2);
    edgeSel = 2'd3; preSel = 2'd2; do_reset(); pulses(8);
    check("R2 every 4th edge", nCaps, 4);
    preSel = 2'd3; do_reset(); pulses(8);
    check("R2 every 8th edge", nCaps, 2);
    preSel = 2'd0;

    // R4 latency with filter length 4
    edgeSel = 2'd0; filtLen = 4'd4; do_reset();
    sigIn[0] = 1'b1;
    k = 0;
    while (!capFlag && k < 50) begin @(negedge clk); k++; end
    check("R4 edge to flag latency", k, 7);
    repeat (10) @(negedge clk);

    // R3 glitch rejection then acceptance
    do_reset();
    for (int i = 0; i < 3; i++) pulse(0, 3, 2);
    repeat (10) @(negedge clk);
    check("R3 short glitches rejected", nCaps, 0);
    pulse(0, 6, 10);
    check("R3 full-length pulse accepted", nCaps, 1);
    filtLen = 4'd0; do_reset(); pulses(2);
    check("R3 zero length acts as one", nCaps, 2);
    filtLen = 4'd2;

    // R9 xor front end
    edgeSel = 2'd2; xorMode = 1'b1; do_reset();
    sigIn[1] = 1'b1; repeat (8) @(negedge clk);
    sigIn[2] = 1'b1; repeat (8) @(negedge clk);
    sigIn[0] = 1'b1; repeat (12) @(negedge clk);
    check("R9 xor edges captured", nCaps, 3);
    xorMode = 1'b0; do_reset();
    pulse(1, 6, 6); pulse(2, 6, 6);
    repeat (10) @(negedge clk);
    check("R9 extra lines ignored", nCaps, 0);
    check("R9 no flag from extra lines", int'(capFlag), 0);

    // R8 clear on capture
    edgeSel = 2'd0; clrOnCap = 1'b1; do_reset(); pulses(3);
    check("R8 counter reset pulses", nCtr, 3);
    clrOnCap = 1'b0; do_reset(); pulses(3);
    check("R8 no reset when disabled", nCtr, 0);

    // R6 and R7 flags
    autoRd = 1'b0; do_reset(); pulses(1);
    check("R6 flag held until read", int'(capFlag), 1);
    manRd = 1'b1; @(negedge clk); manRd = 1'b0;
    check("R6 read clears flag", int'(capFlag), 0);
    pulses(1);
    check("R7 no overcapture after read", int'(ovcFlag), 0);
    pulses(1);
    check("R7 overcapture set", int'(ovcFlag), 1);
    manRd = 1'b1; @(negedge clk); manRd = 1'b0;
    check("R7 read leaves overcapture", int'(ovcFlag), 1);
    ovcClr = 1'b1; @(negedge clk); ovcClr = 1'b0;
    check("R7 explicit clear", int'(ovcFlag), 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule